// File: doc/BRIEF.md
# Short Vector Register Sequencer

This block turns one short-vector floating-point instruction into a series of scalar operations. When a start is accepted it captures a destination register number and two source register numbers. Each number is 5 bits wide: a 2-bit bank and a 3-bit index. The block also captures an iteration length, a stride selector and two flags that describe the operation. For each iteration it presents the three register numbers to an external execute unit with a one-cycle issue pulse. It then waits for that unit to report completion together with its exception flags.

Between iterations the destination and the first source step forward by the stride, wrapping inside their bank. The second source steps the same way, unless it lives in bank 0: a bank-0 second source stays put, so a scalar operand can be combined with a vector. Exception flags from all iterations are merged by OR, and an exception does not stop the sequence. After the last completion, a one-cycle done pulse presents the merged flags. The execute datapath and the register file sit outside this block.

Top module: `svs_sequencer`

## Requirements
- R1: A register number splits into a bank (bits 4:3) and an index within the bank (bits 2:0); stepping never changes the bank.
- R2: The stride is 2 when the 2-bit stride field equals 2'b11, and 1 for 2'b00, 2'b01 and 2'b10.
- R3: Exactly one iteration runs when the effective destination is in bank 0 or `op_scalar_i` is set, whatever the length field holds.
- R4: Otherwise the number of iterations is `len_i` + 1, so the 3-bit field gives 1 to 8 iterations.
- R5: After each completed iteration that is not the last, the destination and the first source index advance by the stride modulo 8, with the bank unchanged. This applies to the first source even when it is in bank 0.
- R6: The second source advances like the first source only when its bank is nonzero; a bank-0 second source keeps its value for every iteration.
- R7: `flags_o` at the done pulse equals the OR of the exception flags returned by every iteration, and the sequence continues after an iteration that returns nonzero flags.
- R8: When `op_dbl_i` is set, the destination is taken from `dbl_dst_i` instead of `dst_i`, and exactly one iteration runs.
- R9: `busy_o` is high from the cycle after an accepted start until the last completion. `done_o` is a one-cycle pulse in the first cycle in which `busy_o` is low again. After reset, `busy_o`, `issue_o`, `done_o` and `flags_o` are all zero.
- R10: A start raised while `busy_o` is high is ignored: the register numbers, the iteration count and the flags of the running sequence are unaffected.
- R11: `issue_o` is high for exactly one cycle per iteration, and the register numbers stay stable until that iteration's `exec_done_i`. The next issue follows in the cycle after the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a sequence (accepted only when idle) |
| op_scalar_i | input | 1 | Operation is scalar-only |
| op_dbl_i | input | 1 | Operation writes a double-precision destination |
| dst_i | input | 5 | Single-precision destination register number |
| dbl_dst_i | input | 5 | Destination number used when `op_dbl_i` is set |
| src_a_i | input | 5 | First source register number |
| src_b_i | input | 5 | Second source register number |
| len_i | input | 3 | Iteration count minus one |
| stride_i | input | 2 | Stride selector (2'b11 gives 2, else 1) |
| exec_done_i | input | 1 | Execute unit finished the current iteration |
| exec_flags_i | input | 5 | Exception flags of the finished iteration |
| busy_o | output | 1 | Sequence in progress |
| issue_o | output | 1 | One-cycle request for the current iteration |
| issue_dst_o | output | 5 | Current destination register number |
| issue_src_a_o | output | 5 | Current first source register number |
| issue_src_b_o | output | 5 | Current second source register number |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| flags_o | output | 5 | Merged exception flags of the last sequence |

## Verification
The bench builds the block with its default parameters: 5-bit register numbers with 3 index bits, a 3-bit length field and 5 flag bits. These values make the full eight-iteration sequence reachable, together with wraparound of every bank index under both strides and a distinct flag bit for each of five iterations. That is enough to show that nothing gets lost in the merge. The same values cover bank-0 destinations and second sources, the double-destination override, and a start raised in the middle of a sequence.

// File: rtl/svs_pkg.sv
package svs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } svs_state_e;

  localparam int STEP_W = 2;
endpackage

// File: rtl/svs_reg_walker.sv
module svs_reg_walker #(
  parameter int REG_W     = 5,
  parameter int IDX_W     = 3,
  parameter int STEP_W    = 2,
  parameter bit FIX_BANK0 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [REG_W-1:0]  load_val_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] stride_i,
  output logic [REG_W-1:0]  reg_o
);
  localparam int BANK_W = REG_W - IDX_W;

  logic [REG_W-1:0]  reg_q, reg_d;
  logic              reg_en;
  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  idx, idx_step;
  logic              hold;

  assign bank = reg_q[REG_W-1:IDX_W];
  assign idx  = reg_q[IDX_W-1:0];

  generate
    if (FIX_BANK0) begin : g_fix
      assign hold = (bank == '0);
    end else begin : g_free
      assign hold = 1'b0;
    end
  endgenerate

  always_comb begin
    idx_step = idx + IDX_W'(stride_i);
    reg_en   = load_i || (adv_i && !hold);
    if (load_i) reg_d = load_val_i;
    else        reg_d = {bank, idx_step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end

  assign reg_o = reg_q;

  AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (reg_q[REG_W-1:IDX_W] == $past(reg_q[REG_W-1:IDX_W]))); // R1

  AST_INDEX_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && (stride_i != '0) && !(FIX_BANK0 && (reg_q[REG_W-1:IDX_W] == '0)))
      |=> !$stable(reg_q)); // R5

  generate
    if (FIX_BANK0) begin : g_fix_chk
      AST_BANK0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && (reg_q[REG_W-1:IDX_W] == '0)) |=> $stable(reg_q)); // R6
    end
  endgenerate
endmodule

// File: rtl/svs_iter_ctrl.sv
module svs_iter_ctrl
  import svs_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             scalar_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             exec_done_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             issue_o,
  output logic             done_o
);
  svs_state_e       st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             rem_en;
  logic             fire;
  logic             done_q;

  always_comb begin
    load_o = start_i && (st_q == ST_IDLE);
    fire   = (st_q == ST_WAIT) && exec_done_i;
    last_o = fire && (rem_q == '0);
    adv_o  = fire && (rem_q != '0);

    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (load_o) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (fire) st_d = last_o ? ST_IDLE : ST_ISSUE;
      default:  st_d = ST_IDLE;
    endcase

    rem_en = load_o || adv_o;
    if (load_o) rem_d = scalar_i ? '0 : len_i;
    else        rem_d = rem_q - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= last_o;
      if (rem_en) rem_q <= rem_d;
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign issue_o = (st_q == ST_ISSUE);
  assign done_o  = done_q;

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R9

  AST_SCALAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && scalar_i) |=> (rem_q == '0)); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !fire) |=> $stable(rem_q)); // R10

  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> !issue_o); // R11
endmodule

// File: rtl/svs_flag_acc.sv
module svs_flag_acc #(
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic              last_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] acc_q, acc_d, res_q, merged;
  logic              acc_en;

  always_comb begin
    merged = acc_q | flags_i;
    acc_en = clear_i || take_i;
    acc_d  = clear_i ? '0 : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (last_i) res_q <= merged;
    end
  end

  assign flags_o = res_q;

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R7
endmodule

// File: rtl/svs_sequencer.sv
module svs_sequencer
  import svs_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int IDX_W  = 3,
  parameter int LEN_W  = 3,
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_scalar_i,
  input  logic              op_dbl_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  dbl_dst_i,
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        stride_i,
  input  logic              exec_done_i,
  input  logic [FLAG_W-1:0] exec_flags_i,
  output logic              busy_o,
  output logic              issue_o,
  output logic [REG_W-1:0]  issue_dst_o,
  output logic [REG_W-1:0]  issue_src_a_o,
  output logic [REG_W-1:0]  issue_src_b_o,
  output logic              done_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [REG_W-1:0]  eff_dst;
  logic              scalar;
  logic              load, adv, last;
  logic [STEP_W-1:0] stride_q, stride_d;

  always_comb begin
    eff_dst  = op_dbl_i ? dbl_dst_i : dst_i;
    scalar   = op_scalar_i || op_dbl_i || (eff_dst[REG_W-1:IDX_W] == '0);
    stride_d = (stride_i == 2'b11) ? STEP_W'(2) : STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stride_q <= STEP_W'(1);
    else if (load) stride_q <= stride_d;
  end

  svs_iter_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scalar_i(scalar),
    .len_i(len_i), .exec_done_i(exec_done_i), .load_o(load), .adv_o(adv),
    .last_o(last), .busy_o(busy_o), .issue_o(issue_o), .done_o(done_o)
  );

  svs_reg_walker #(.REG_W(REG_W), .IDX_W(IDX_W), .STEP_W(STEP_W), .FIX_BANK0(1'b0)) u_dst (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(eff_dst),
    .adv_i(adv), .stride_i(stride_q), .reg_o(issue_dst_o)
  );

  svs_reg_walker #(.REG_W(REG_W), .IDX_W(IDX_W), .STEP_W(STEP_W), .FIX_BANK0(1'b0)) u_src_a (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(src_a_i),
    .adv_i(adv), .stride_i(stride_q), .reg_o(issue_src_a_o)
  );

  svs_reg_walker #(.REG_W(REG_W), .IDX_W(IDX_W), .STEP_W(STEP_W), .FIX_BANK0(1'b1)) u_src_b (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(src_b_i),
    .adv_i(adv), .stride_i(stride_q), .reg_o(issue_src_b_o)
  );

  svs_flag_acc #(.FLAG_W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .clear_i(load), .take_i(adv || last),
    .last_i(last), .flags_i(exec_flags_i), .flags_o(flags_o)
  );

  AST_DBL_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && op_dbl_i) |=> (issue_dst_o == $past(dbl_dst_i))); // R8

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !exec_done_i) |=> ($stable(issue_dst_o) && $stable(issue_src_a_o) && $stable(issue_src_b_o))); // R11
endmodule

// File: tb/sim_svs_sequencer.sv
`timescale 1ns/1ps
module sim_svs_sequencer;
  typedef struct packed {
    logic [4:0] dst, sa, sb, dd;
    logic [2:0] len;
    logic [1:0] st;
    logic       sc, db;
    logic [4:0] seed;
    logic [3:0] n;
  } vec_t;

  // dst, src_a, src_b, dbl_dst, len, stride, scalar, dbl, flag seed, expected iterations
  localparam vec_t TBL [9] = '{
    '{5'd8,  5'd16, 5'd24, 5'd0,  3'd3, 2'd0, 1'b0, 1'b0, 5'b10101, 4'd4},
    '{5'd14, 5'd21, 5'd3,  5'd0,  3'd4, 2'd3, 1'b0, 1'b0, 5'b11111, 4'd5},
    '{5'd5,  5'd9,  5'd10, 5'd0,  3'd7, 2'd3, 1'b0, 1'b0, 5'b00000, 4'd1},
    '{5'd9,  5'd17, 5'd25, 5'd0,  3'd5, 2'd0, 1'b1, 1'b0, 5'b00001, 4'd1},
    '{5'd8,  5'd11, 5'd12, 5'd20, 3'd6, 2'd0, 1'b0, 1'b1, 5'b00010, 4'd1},
    '{5'd31, 5'd15, 5'd23, 5'd0,  3'd7, 2'd1, 1'b0, 1'b0, 5'b01010, 4'd8},
    '{5'd24, 5'd0,  5'd0,  5'd0,  3'd1, 2'd3, 1'b0, 1'b0, 5'b10000, 4'd2},
    '{5'd12, 5'd13, 5'd2,  5'd0,  3'd2, 2'd2, 1'b0, 1'b0, 5'b00100, 4'd3},
    '{5'd16, 5'd1,  5'd26, 5'd0,  3'd0, 2'd0, 1'b0, 1'b0, 5'b00011, 4'd1}
  };

  logic       clk, rst_n;
  logic       start_i, op_scalar_i, op_dbl_i, exec_done_i;
  logic [4:0] dst_i, dbl_dst_i, src_a_i, src_b_i, exec_flags_i;
  logic [2:0] len_i;
  logic [1:0] stride_i;
  logic       busy_o, issue_o, done_o;
  logic [4:0] issue_dst_o, issue_src_a_o, issue_src_b_o, flags_o;

  int checks = 0;
  int fails  = 0;

  svs_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_scalar_i(op_scalar_i),
    .op_dbl_i(op_dbl_i), .dst_i(dst_i), .dbl_dst_i(dbl_dst_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .len_i(len_i), .stride_i(stride_i), .exec_done_i(exec_done_i),
    .exec_flags_i(exec_flags_i), .busy_o(busy_o), .issue_o(issue_o),
    .issue_dst_o(issue_dst_o), .issue_src_a_o(issue_src_a_o),
    .issue_src_b_o(issue_src_b_o), .done_o(done_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R1/R5/R6 model: bank kept, index steps modulo 8, bank-0 hold only where asked
  function automatic logic [4:0] step(input logic [4:0] r, input int s, input bit fix);
    if (fix && r[4:3] == 2'b00) return r;
    return {r[4:3], 3'(r[2:0] + 3'(s))};
  endfunction

  task automatic run_op(input vec_t v, input bit poke);
    logic [4:0] ed, ea, eb, acc, f;
    int st;
    string cnt_req;
    ed  = v.db ? v.dd : v.dst;
    ea  = v.sa;
    eb  = v.sb;
    st  = (v.st == 2'b11) ? 2 : 1;
    acc = '0;
    cnt_req = (v.sc || v.db || ed[4:3] == 2'b00) ? "R3" : "R4";
    @(negedge clk);
    start_i = 1'b1; dst_i = v.dst; src_a_i = v.sa; src_b_i = v.sb; dbl_dst_i = v.dd;
    len_i = v.len; stride_i = v.st; op_scalar_i = v.sc; op_dbl_i = v.db;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < int'(v.n); i++) begin
      chk(issue_o == 1'b1, "R11", "issue pulse", int'(issue_o), 1);
      chk(busy_o == 1'b1, "R9", "busy during run", int'(busy_o), 1);
      chk(issue_dst_o == ed, v.db ? "R8" : "R5", "dst (R1 R2)", int'(issue_dst_o), int'(ed));
      chk(issue_src_a_o == ea, "R5", "src_a (R2)", int'(issue_src_a_o), int'(ea));
      chk(issue_src_b_o == eb, "R6", "src_b", int'(issue_src_b_o), int'(eb));
      @(negedge clk);
      chk(issue_o == 1'b0, "R11", "issue one cycle", int'(issue_o), 0);
      f = v.seed & (5'b00001 << (i % 5));
      acc |= f;
      exec_done_i = 1'b1; exec_flags_i = f;
      if (poke) begin
        // R10: start during a running sequence must be ignored
        start_i = 1'b1; dst_i = 5'd17; src_a_i = 5'd30; src_b_i = 5'd29; len_i = 3'd7;
      end
      @(negedge clk);
      exec_done_i = 1'b0; exec_flags_i = '0; start_i = 1'b0;
      if (i < int'(v.n) - 1) begin
        chk(done_o == 1'b0, cnt_req, "no early done", int'(done_o), 0);
        ed = step(ed, st, 1'b0);
        ea = step(ea, st, 1'b0);
        eb = step(eb, st, 1'b1);
      end else begin
        chk(done_o == 1'b1, cnt_req, "done after expected count", int'(done_o), 1);
        chk(busy_o == 1'b0, "R9", "busy low at done", int'(busy_o), 0);
        chk(flags_o == acc, "R7", "merged flags", int'(flags_o), int'(acc));
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done single pulse", int'(done_o), 0);
    chk(issue_o == 1'b0, cnt_req, "no extra issue", int'(issue_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_scalar_i = 1'b0; op_dbl_i = 1'b0; exec_done_i = 1'b0;
    dst_i = '0; dbl_dst_i = '0; src_a_i = '0; src_b_i = '0; exec_flags_i = '0;
    len_i = '0; stride_i = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R9", "reset busy", int'(busy_o), 0);
    chk(issue_o == 1'b0, "R9", "reset issue", int'(issue_o), 0);
    chk(done_o == 1'b0, "R9", "reset done", int'(done_o), 0);
    chk(flags_o == 5'd0, "R9", "reset flags", int'(flags_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 9; k++) run_op(TBL[k], 1'b0);

    // R10: second start raised while busy, sequence must be unchanged
    run_op('{5'd8, 5'd16, 5'd24, 5'd0, 3'd2, 2'd0, 1'b0, 1'b0, 5'b00011, 4'd3}, 1'b1);
    // a new start is accepted once idle again (R10)
    run_op('{5'd10, 5'd18, 5'd4, 5'd0, 3'd1, 2'd3, 1'b0, 1'b0, 5'b00100, 4'd2}, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule